// File: doc/BRIEF.md
# Round-Robin ADC Channel Scanner

This block drives an external single-channel converter through a list of up to 32 selector slots held in registers. Each slot is one byte. Its low five bits name an input channel. Its high three bits drive three bias-control outputs, and those outputs hold while that slot's conversion is in flight. Software first sets an enable bit and then a start bit. The scanner then walks the slots from slot 0. For each slot it issues one start pulse and waits for the converter's done strobe. It stores the 10-bit value, together with a gain flag, in the result slot that has the same index.

A slot whose channel field is 31 ends the round. So does running past the last slot. At the end of a round a round-done flag and an ADC summary bit are raised, and an interrupt output follows the summary bit unless that bit is masked. The scanner then waits a programmed number of 1 kHz ticks. If start is still set it begins a new round, and the new results overwrite the old ones in place. A fixed set of channels is reserved. Two further channels become usable only when their own enable bits are set. When a slot selects a reserved or disabled channel, no conversion is started and zero is written to its result slot.

Top module: `adc_round_scanner`

## Requirements
- R1: In a selector byte, bits [4:0] are the channel and bits [7:5] are the bias code. While a conversion for that slot is in flight, `chanSel` and `biasOut` carry those fields, and both outputs are 0 at all other times. `adcStart` is a one-cycle pulse per conversion.
- R2: Result slot i reads at address 0x20+i as {gain, data[9:0]} in bits [10:0], with the upper bits 0. Selector slot i reads and writes at address i.
- R3: Control register 0x40 has these fields: bit0 enable, bit1 start, bits[4:2] sleep code, bit5 channel-22 enable, bit6 channel-25 enable. Start can only be held while enable is 1. No conversion happens unless both enable and start are 1.
- R4: A slot with channel 31 ends the round. No conversion is issued for it and its result slot is not written.
- R5: At round end, bit0 of 0x41 (round-done) is set. Bit1 of 0x43 (ADC summary) is also set unless bit0 of 0x42 (round-done mask) is 1. Writing 1 to a flag bit clears it.
- R6: `irq` is high exactly when the summary bit is set and bit1 of 0x44 (top mask) is 0.
- R7: After a round, the scanner waits round(code*27/7) ticks of `msTick` before the next round begins. Code 0 restarts at once.
- R8: Each new round starts from slot 0 and overwrites earlier results with new ones.
- R9: Channels 4, 5, 23, 24 and 26 to 30 are reserved. Channels 22 and 25 are reserved while their enable bits are 0. A reserved slot issues no conversion and writes 0 to its result slot.
- R10: Writing enable = 0 stops a round within one clock. Start is cleared and no further conversions are issued.
- R11: If none of the 32 slots holds channel 31, the round ends after slot 31, with 32 conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 7 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| msTick | input | 1 | One-cycle 1 kHz tick |
| adcStart | output | 1 | Conversion start pulse |
| adcDone | input | 1 | Conversion done strobe |
| adcData | input | 10 | Conversion value, valid with done |
| adcGain | input | 1 | Gain setting used, valid with done |
| chanSel | output | 5 | Selected channel during conversion |
| biasOut | output | 3 | Bias control during conversion |
| irq | output | 1 | Interrupt output |

## Verification
The scan is exercised with four list shapes:
- A short list that mixes usable channels, a reserved channel, a gated channel and a stop slot. It separates conversion order, bias routing, zero-writes and stop handling.
- The same list with one gate bit turned off and a new data pattern. It shows that results are overwritten and that gating decides whether a channel is converted.
- A full list with no stop marker. It checks that the round ends after exactly 32 conversions.
- A running list that is aborted by clearing enable.

Sleep codes 0, 1, 3 and 7 are measured against tick-count windows. The two mask bits are toggled separately, so that the round-done flag, the summary bit and the interrupt pin can each be told apart.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int SLOT_IDX_W = 5;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_EVAL,
    SEQ_WAIT,
    SEQ_END,
    SEQ_SLEEP
  } seqState_e;

  typedef struct packed {
    logic resWr;
    logic resZero;
    logic roundEnd;
  } seqStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int BIAS_W = 3,
  parameter int SLEEP_W = 3,
  parameter int SLEEP_MAX = 27,
  parameter int STOP_CODE = 31,
  parameter int GATE_A = 22,
  parameter int GATE_B = 25,
  parameter logic [31:0] RSVD_MASK = 32'h7D80_0030
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEn,
  input  logic                  cfgStart,
  input  logic [SLEEP_W-1:0]    cfgSleep,
  input  logic                  gateAEn,
  input  logic                  gateBEn,
  input  logic                  msTick,
  input  logic                  adcDone,
  input  logic [CH_W+BIAS_W-1:0] curEntry,
  output logic [SLOT_IDX_W-1:0] slotIdx,
  output seqStrobe_t            strb,
  output logic                  adcStart,
  output logic [CH_W-1:0]       chanSel,
  output logic [BIAS_W-1:0]     biasOut
);
  localparam int TICK_W = $clog2(SLEEP_MAX + 1);
  localparam int CODE_MAX = (1 << SLEEP_W) - 1;
  localparam logic [SLOT_IDX_W-1:0] LAST_IDX = '1;

  seqState_e state;
  logic [TICK_W-1:0] sleepCnt;
  logic [TICK_W-1:0] sleepTarget;
  logic [CH_W-1:0] curChan;
  logic isStop, isRsvd, isLast;

  assign curChan = curEntry[CH_W-1:0];
  assign isStop  = (curChan == CH_W'(STOP_CODE));
  assign isLast  = (slotIdx == LAST_IDX);
  assign isRsvd  = RSVD_MASK[curChan]
                 | ((curChan == CH_W'(GATE_A)) && !gateAEn)
                 | ((curChan == CH_W'(GATE_B)) && !gateBEn);

  // rounded code*SLEEP_MAX/CODE_MAX
  always_comb begin
    int prod;
    prod = (int'(cfgSleep) * SLEEP_MAX * 2 + CODE_MAX) / (2 * CODE_MAX);
    sleepTarget = TICK_W'(prod);
  end

  always_comb begin
    strb = '0;
    if (cfgEn) begin
      strb.resWr    = ((state == SEQ_EVAL) && !isStop && isRsvd)
                    || ((state == SEQ_WAIT) && adcDone);
      strb.resZero  = (state == SEQ_EVAL);
      strb.roundEnd = (state == SEQ_END);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !cfgEn) begin
      state    <= SEQ_IDLE;
      slotIdx  <= '0;
      adcStart <= 1'b0;
      sleepCnt <= '0;
    end else begin
      adcStart <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (cfgStart) begin
            state   <= SEQ_EVAL;
            slotIdx <= '0;
          end
        end
        SEQ_EVAL: begin
          if (isStop) begin
            state <= SEQ_END;
          end else if (isRsvd) begin
            if (isLast) state <= SEQ_END;
            else slotIdx <= slotIdx + 1'b1;
          end else begin
            adcStart <= 1'b1;
            state    <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (adcDone) begin
            if (isLast) begin
              state <= SEQ_END;
            end else begin
              slotIdx <= slotIdx + 1'b1;
              state   <= SEQ_EVAL;
            end
          end
        end
        SEQ_END: begin
          state    <= SEQ_SLEEP;
          sleepCnt <= '0;
        end
        SEQ_SLEEP: begin
          if (sleepCnt >= sleepTarget) begin
            slotIdx <= '0;
            state   <= cfgStart ? SEQ_EVAL : SEQ_IDLE;
          end else if (msTick) begin
            sleepCnt <= sleepCnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign chanSel = (state == SEQ_WAIT) ? curChan : '0;
  assign biasOut = (state == SEQ_WAIT) ? curEntry[CH_W+BIAS_W-1:CH_W] : '0;

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);
  p_no_stop_conv_r4: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> (chanSel != CH_W'(STOP_CODE)));
  p_no_rsvd_conv_r9: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> !RSVD_MASK[chanSel]);
  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> (state == SEQ_IDLE) && !adcStart);
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int BIAS_W = 3,
  parameter int DATA_W = 10,
  parameter int SLEEP_W = 3,
  parameter int RD_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [SLOT_IDX_W+1:0]  regAddr,
  input  logic [CH_W+BIAS_W-1:0] regWdata,
  output logic [RD_W-1:0]        regRdata,
  input  seqStrobe_t             strb,
  input  logic [SLOT_IDX_W-1:0]  slotIdx,
  input  logic [DATA_W-1:0]      adcData,
  input  logic                   adcGain,
  output logic [CH_W+BIAS_W-1:0] curEntry,
  output logic                   cfgEn,
  output logic                   cfgStart,
  output logic [SLEEP_W-1:0]     cfgSleep,
  output logic                   gateAEn,
  output logic                   gateBEn,
  output logic                   irq
);
  localparam int N_SLOTS = 1 << SLOT_IDX_W;
  localparam int ENT_W = CH_W + BIAS_W;
  localparam int RES_W = DATA_W + 1;
  localparam logic [1:0] PG_TAB = 2'd0;
  localparam logic [1:0] PG_RES = 2'd1;
  localparam logic [1:0] PG_CFG = 2'd2;
  localparam logic [SLOT_IDX_W-1:0] O_CTRL = 0;
  localparam logic [SLOT_IDX_W-1:0] O_FLAG = 1;
  localparam logic [SLOT_IDX_W-1:0] O_FMSK = 2;
  localparam logic [SLOT_IDX_W-1:0] O_SUM  = 3;
  localparam logic [SLOT_IDX_W-1:0] O_SMSK = 4;

  logic [ENT_W-1:0] selTab [N_SLOTS];
  logic [RES_W-1:0] resFile [N_SLOTS];
  logic rndFlag, rndMask, adcSum, topMask;

  logic [1:0] page;
  logic [SLOT_IDX_W-1:0] ofs;
  logic wrCfg;
  assign page  = regAddr[SLOT_IDX_W+1:SLOT_IDX_W];
  assign ofs   = regAddr[SLOT_IDX_W-1:0];
  assign wrCfg = regWr && (page == PG_CFG);

  assign curEntry = selTab[slotIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_SLOTS; i++) selTab[i] <= '0;
    end else if (regWr && page == PG_TAB) begin
      selTab[ofs] <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_SLOTS; i++) resFile[i] <= '0;
    end else if (strb.resWr) begin
      resFile[slotIdx] <= strb.resZero ? '0 : {adcGain, adcData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      cfgStart <= 1'b0;
      cfgSleep <= '0;
      gateAEn  <= 1'b0;
      gateBEn  <= 1'b0;
      rndMask  <= 1'b0;
      topMask  <= 1'b0;
    end else begin
      if (wrCfg && ofs == O_CTRL) begin
        cfgEn    <= regWdata[0];
        cfgStart <= regWdata[1] & regWdata[0];
        cfgSleep <= regWdata[2 +: SLEEP_W];
        gateAEn  <= regWdata[2 + SLEEP_W];
        gateBEn  <= regWdata[3 + SLEEP_W];
      end else if (!cfgEn) begin
        cfgStart <= 1'b0;
      end
      if (wrCfg && ofs == O_FMSK) rndMask <= regWdata[0];
      if (wrCfg && ofs == O_SMSK) topMask <= regWdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rndFlag <= 1'b0;
      adcSum  <= 1'b0;
    end else begin
      if (strb.roundEnd) rndFlag <= 1'b1;
      else if (wrCfg && ofs == O_FLAG && regWdata[0]) rndFlag <= 1'b0;
      if (strb.roundEnd && !rndMask) adcSum <= 1'b1;
      else if (wrCfg && ofs == O_SUM && regWdata[1]) adcSum <= 1'b0;
    end
  end

  assign irq = adcSum && !topMask;

  always_comb begin
    regRdata = '0;
    case (page)
      PG_TAB: regRdata = RD_W'(selTab[ofs]);
      PG_RES: regRdata = RD_W'(resFile[ofs]);
      PG_CFG: begin
        case (ofs)
          O_CTRL: regRdata = RD_W'({gateBEn, gateAEn, cfgSleep, cfgStart, cfgEn});
          O_FLAG: regRdata = RD_W'(rndFlag);
          O_FMSK: regRdata = RD_W'(rndMask);
          O_SUM:  regRdata = RD_W'({adcSum, 1'b0});
          O_SMSK: regRdata = RD_W'({topMask, 1'b0});
          default: regRdata = '0;
        endcase
      end
      default: regRdata = '0;
    endcase
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.roundEnd |=> rndFlag);
  p_sum_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcSum) |-> $past(strb.roundEnd) && !$past(rndMask));
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    topMask |-> !irq);
  p_start_needs_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |-> cfgEn);
endmodule

// File: rtl/adc_round_scanner.sv
module adc_round_scanner
  import scan_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int BIAS_W = 3,
  parameter int DATA_W = 10,
  parameter int SLEEP_W = 3,
  parameter int SLEEP_MAX = 27,
  parameter int STOP_CODE = 31,
  parameter int GATE_A = 22,
  parameter int GATE_B = 25,
  parameter logic [31:0] RSVD_MASK = 32'h7D80_0030,
  parameter int RD_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [SLOT_IDX_W+1:0]  regAddr,
  input  logic [CH_W+BIAS_W-1:0] regWdata,
  output logic [RD_W-1:0]        regRdata,
  input  logic                   msTick,
  output logic                   adcStart,
  input  logic                   adcDone,
  input  logic [DATA_W-1:0]      adcData,
  input  logic                   adcGain,
  output logic [CH_W-1:0]        chanSel,
  output logic [BIAS_W-1:0]      biasOut,
  output logic                   irq
);
  seqStrobe_t strb;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic [CH_W+BIAS_W-1:0] curEntry;
  logic cfgEn, cfgStart, gateAEn, gateBEn;
  logic [SLEEP_W-1:0] cfgSleep;

  scan_ctrl #(
    .CH_W(CH_W), .BIAS_W(BIAS_W), .SLEEP_W(SLEEP_W), .SLEEP_MAX(SLEEP_MAX),
    .STOP_CODE(STOP_CODE), .GATE_A(GATE_A), .GATE_B(GATE_B), .RSVD_MASK(RSVD_MASK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgStart(cfgStart), .cfgSleep(cfgSleep),
    .gateAEn(gateAEn), .gateBEn(gateBEn), .msTick(msTick), .adcDone(adcDone),
    .curEntry(curEntry), .slotIdx(slotIdx), .strb(strb), .adcStart(adcStart),
    .chanSel(chanSel), .biasOut(biasOut)
  );

  scan_datapath #(
    .CH_W(CH_W), .BIAS_W(BIAS_W), .DATA_W(DATA_W), .SLEEP_W(SLEEP_W), .RD_W(RD_W)
  ) uData (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .strb(strb), .slotIdx(slotIdx), .adcData(adcData),
    .adcGain(adcGain), .curEntry(curEntry), .cfgEn(cfgEn), .cfgStart(cfgStart),
    .cfgSleep(cfgSleep), .gateAEn(gateAEn), .gateBEn(gateBEn), .irq(irq)
  );
endmodule

// File: tb/sim_adc_round_scanner.sv
`timescale 1ns/1ps
module sim_adc_round_scanner;
  localparam int TICK_P = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [6:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [15:0] regRdata;
  logic msTick = 1'b0;
  logic adcStart;
  logic adcDone = 1'b0;
  logic [9:0] adcData = '0;
  logic adcGain = 1'b0;
  logic [4:0] chanSel;
  logic [2:0] biasOut;
  logic irq;

  int total = 0;
  int failed = 0;
  int base = 1;
  int convCount = 0;
  int pendCnt = 0;
  int tickDiv = 0;
  logic [4:0] pendChan = '0;
  logic [7:0] convLog [64];

  always #5 clk = ~clk;

  adc_round_scanner u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .msTick(msTick), .adcStart(adcStart), .adcDone(adcDone),
    .adcData(adcData), .adcGain(adcGain), .chanSel(chanSel), .biasOut(biasOut), .irq(irq)
  );

  function automatic logic [10:0] expRes(int ch, int b);
    logic [9:0] d;
    d = 10'((ch * 37 + b) & 1023);
    return {1'((ch + b) & 1), d};
  endfunction

  // converter model, tick source and conversion logger
  always @(negedge clk) begin
    adcDone <= 1'b0;
    if (pendCnt == 1) begin
      adcDone <= 1'b1;
      adcData <= expRes(int'(pendChan), base)[9:0];
      adcGain <= expRes(int'(pendChan), base)[10];
    end
    if (pendCnt > 0) pendCnt <= pendCnt - 1;
    if (adcStart) begin
      pendCnt <= 3;
      pendChan <= chanSel;
      convLog[convCount % 64] <= {biasOut, chanSel};
      convCount <= convCount + 1;
    end
    tickDiv <= (tickDiv == TICK_P - 1) ? 0 : tickDiv + 1;
    msTick <= (tickDiv == TICK_P - 1);
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkRange(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wrReg(int a, int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 7'(a); regWdata = 8'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(int a, output int v);
    @(negedge clk);
    regAddr = 7'(a);
    #1 v = int'(regRdata);
  endtask

  function automatic int ctlVal(int en, int st, int slp, int ga, int gb);
    return en | (st << 1) | (slp << 2) | (ga << 5) | (gb << 6);
  endfunction

  task automatic waitFlag();
    int v;
    for (int i = 0; i < 20000; i++) begin
      rdReg(7'h41, v);
      if (v[0]) return;
    end
    chk("R5 round-done timeout", 0, 1);
  endtask

  initial begin
    int v, n0, n1, c, tgt;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 irq after reset", int'(irq), 0);
    chk("R1 adcStart after reset", int'(adcStart), 0);
    rdReg(7'h40, v); chk("R3 control after reset", v, 0);
    rdReg(7'h41, v); chk("R5 flag after reset", v, 0);

    // slots: ch0/b5, ch6/b2, ch4 rsvd, ch22 gated, ch3/b3, ch25 gated, stop/b4
    wrReg(0, 8'hA0); wrReg(1, 8'h46); wrReg(2, 8'hE4); wrReg(3, 8'h36);
    wrReg(4, 8'h63); wrReg(5, 8'h19); wrReg(6, 8'h9F);
    rdReg(1, v); chk("R2 selector readback", v, 8'h46);

    // R3: start without enable does nothing
    wrReg(7'h40, ctlVal(0, 1, 0, 1, 1));
    repeat (50) @(negedge clk);
    chk("R3 no conversion without enable", convCount, 0);
    rdReg(7'h40, v); chk("R3 start dropped without enable", v & 2, 0);

    base = 1;
    wrReg(7'h40, ctlVal(1, 1, 0, 1, 1));
    waitFlag();
    n0 = convCount;
    wrReg(7'h40, ctlVal(1, 0, 0, 1, 1));
    repeat (300) @(negedge clk);
    chk("R4 conversions in round", n0, 5);
    chk("R1 slot0 ch/bias", int'(convLog[0]), 8'hA0);
    chk("R1 slot1 ch/bias", int'(convLog[1]), 8'h46);
    chk("R9 gated ch22 enabled", int'(convLog[2]), 8'h36);
    chk("R1 slot4 ch/bias", int'(convLog[3]), 8'h63);
    chk("R9 gated ch25 enabled", int'(convLog[4]), 8'h19);
    chk("R1 outputs idle", int'(chanSel) + int'(biasOut), 0);
    rdReg(7'h20, v); chk("R2 result slot0", v, int'(expRes(0, 1)));
    rdReg(7'h21, v); chk("R2 result slot1", v, int'(expRes(6, 1)));
    rdReg(7'h22, v); chk("R9 reserved slot zero", v, 0);
    rdReg(7'h23, v); chk("R2 result slot3", v, int'(expRes(22, 1)));
    rdReg(7'h25, v); chk("R2 result slot5", v, int'(expRes(25, 1)));
    rdReg(7'h26, v); chk("R4 stop slot not written", v, 0);
    rdReg(7'h41, v); chk("R5 round flag set", v, 1);
    rdReg(7'h43, v); chk("R5 summary set", v, 2);
    chk("R6 irq asserted", int'(irq), 1);
    wrReg(7'h41, 1); rdReg(7'h41, v); chk("R5 flag w1c", v, 0);
    chk("R6 irq held by summary", int'(irq), 1);
    wrReg(7'h43, 2); rdReg(7'h43, v); chk("R5 summary w1c", v, 0);
    chk("R6 irq cleared", int'(irq), 0);

    // top mask; ch22 gated off; new data pattern
    wrReg(7'h44, 2);
    base = 7;
    wrReg(7'h40, ctlVal(1, 1, 0, 0, 1));
    waitFlag();
    wrReg(7'h40, ctlVal(1, 0, 0, 0, 1));
    repeat (300) @(negedge clk);
    chk("R6 irq masked", int'(irq), 0);
    rdReg(7'h43, v); chk("R6 summary set under mask", v, 2);
    rdReg(7'h23, v); chk("R9 disabled ch22 writes zero", v, 0);
    rdReg(7'h20, v); chk("R8 slot0 overwritten", v, int'(expRes(0, 7)));
    rdReg(7'h25, v); chk("R8 slot5 overwritten", v, int'(expRes(25, 7)));
    wrReg(7'h44, 0);
    chk("R6 irq after unmask", int'(irq), 1);
    wrReg(7'h43, 2); wrReg(7'h41, 1);

    // round-done mask
    wrReg(7'h42, 1);
    wrReg(7'h40, ctlVal(1, 1, 0, 0, 1));
    waitFlag();
    wrReg(7'h40, ctlVal(1, 0, 0, 0, 1));
    repeat (300) @(negedge clk);
    rdReg(7'h43, v); chk("R5 summary suppressed by mask", v, 0);
    chk("R6 irq stays low", int'(irq), 0);
    wrReg(7'h42, 0); wrReg(7'h41, 1);

    // sleep intervals
    foreach (convLog[k]) convLog[k] = '0;
    for (int code = 0; code < 8; code++) begin
      if (code == 0 || code == 1 || code == 3 || code == 7) begin
        tgt = $rtoi(code * 27.0 / 7.0 + 0.5);
        wrReg(7'h40, ctlVal(1, 1, code, 0, 1));
        waitFlag(); wrReg(7'h41, 1);
        waitFlag();
        c = 0;
        while (!adcStart && c < 1000) begin
          @(negedge clk);
          c++;
        end
        chkRange($sformatf("R7 sleep code %0d", code), c,
                 (tgt == 0) ? 0 : (tgt - 1) * TICK_P, tgt * TICK_P + 4);
        wrReg(7'h41, 1);
      end
    end
    wrReg(7'h40, ctlVal(1, 0, 0, 0, 1));
    repeat (600) @(negedge clk);
    wrReg(7'h41, 1);

    // full list without stop
    for (int i = 0; i < 32; i++) wrReg(i, ((i % 8) << 5) | (i % 4));
    wrReg(7'h40, ctlVal(1, 1, 0, 0, 1));
    waitFlag();
    n0 = convCount;
    wrReg(7'h41, 1);
    waitFlag();
    n1 = convCount;
    chk("R11 wrap after slot 31", n1 - n0, 32);

    // abort
    n0 = convCount;
    while (convCount == n0) @(negedge clk);
    wrReg(7'h40, 0);
    n0 = convCount;
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (adcStart || chanSel != 0 || biasOut != 0) c++;
    end
    chk("R10 outputs quiet after abort", c, 0);
    chk("R10 no conversions after abort", convCount - n0, 0);
    rdReg(7'h40, v); chk("R10 start cleared", v, 0);
    wrReg(7'h40, ctlVal(1, 0, 0, 0, 0));
    repeat (60) @(negedge clk);
    chk("R3 enable alone starts nothing", convCount - n0, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #1500000;
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule